// File: doc/BRIEF.md
# Host-to-Service-Processor Command Mailbox

This block is a memory-mapped mailbox that sits between a host CPU and a service processor. It has a 256-byte register window. The host fills a 16-byte outbound payload area and then writes a command word. That write is the doorbell: it latches the word, marks the mailbox busy and interrupts the service processor. The service processor reads the latched command and the outbound payload, and places response bytes in a separate 16-byte inbound area. It then strobes completion with an error flag, an error code and an initiator tag.

The host polls the busy bit in the status word, then checks the error bit, and then reads the response in bytes or in little-endian 32-bit words. If the latched command asked for it, completion also sends a single-cycle pulse to the host, which never needs clearing. A doorbell that arrives while a command is still outstanding is dropped. The drop is recorded in a sticky overrun flag.

Top module: `mbx_ipc_mailbox`

## Requirements
- R1: Reset clears the status word, the latched command, both payload areas and both interrupt outputs to zero.
- R2: A host write to offset 0x00 while not busy latches the whole data word as the command, presents it on `sp_cmd_word`, pulses `sp_cmd_irq` for exactly one cycle after the write edge, and sets busy (status bit 0). Command word fields: bits [7:0] command, bit 8 interrupt-on-completion, bits [15:12] command ID, bits [23:16] payload size.
- R3: A host write to offset 0x00 while busy is dropped. The latched command is unchanged and no service-processor interrupt fires. Status bit 2 (overrun) is set and stays set until the next accepted command clears it.
- R4: `sp_done` while busy clears busy. It loads the error bit (status bit 1) from `sp_done_err`, the error code (status bits [23:16]) from `sp_done_code` and the initiator (status bits [15:8]) from `sp_done_init`. Status bits [7:4] always show the latched command ID. An accepted command clears error, error code and initiator.
- R5: `sp_done` while not busy changes nothing and raises no host interrupt.
- R6: `h_done_irq` pulses for one cycle after an accepted completion only when bit 8 of the latched command is 1.
- R7: Host writes to 0x80–0x8F fill the outbound area, with byte lanes selected by `h_be`. Word k (offsets 0x80+4k) is visible on `sp_wbuf_word` when `sp_wbuf_sel`=k. Host reads of the outbound area and of offset 0x00 return zero.
- R8: The service processor writes inbound word k (offsets 0x90+4k) with byte enables. A host word read returns the aligned word, with the lowest-address byte in bits [7:0]. A host byte read (`h_rd_byte`=1) returns the addressed byte in bits [7:0] and zero above.
- R9: Host writes to the status offset or to the inbound area have no effect.
- R10: Read data is registered. It appears on `h_rdata` the cycle after `h_rd_en` and holds until the next read. Offsets outside the status word and the inbound area read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr_en | input | 1 | Host write strobe |
| h_rd_en | input | 1 | Host read strobe |
| h_rd_byte | input | 1 | Host read is a byte read |
| h_addr | input | 8 | Host byte offset in the window |
| h_wdata | input | 32 | Host write data |
| h_be | input | 4 | Host write byte enables |
| h_rdata | output | 32 | Registered host read data |
| h_done_irq | output | 1 | Completion pulse to the host |
| sp_cmd_irq | output | 1 | Doorbell pulse to the service processor |
| sp_cmd_word | output | 32 | Latched command word |
| sp_wbuf_sel | input | 2 | Outbound word select |
| sp_wbuf_word | output | 32 | Selected outbound word |
| sp_rbuf_we | input | 1 | Inbound word write strobe |
| sp_rbuf_sel | input | 2 | Inbound word select |
| sp_rbuf_be | input | 4 | Inbound write byte enables |
| sp_rbuf_wdata | input | 32 | Inbound write data |
| sp_done | input | 1 | Completion strobe |
| sp_done_err | input | 1 | Error flag carried by completion |
| sp_done_code | input | 8 | Error code carried by completion |
| sp_done_init | input | 8 | Initiator tag carried by completion |

## Verification
The bench rings the doorbell a second time while a command is outstanding. A design that accepted that write would overwrite the latched command and interrupt the service processor twice. It also strobes completion while the mailbox is idle, which a careless design would take as a fresh result that clobbers the error code. It runs completions with the interrupt-on-completion bit both set and clear, to catch a host interrupt that ignores that bit. It also mixes byte and word reads with partial byte enables on both payload areas, which exposes swapped byte lanes and lanes written without being enabled.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int          MBX_AW       = 8;
  localparam logic [7:0]  MBX_CMD_OFS  = 8'h00;
  localparam logic [7:0]  MBX_STAT_OFS = 8'h04;
  localparam logic [7:0]  MBX_WBUF_OFS = 8'h80;
  localparam logic [7:0]  MBX_RBUF_OFS = 8'h90;
  localparam int          MBX_IOC_BIT  = 8;

  // command ID lives in bits [15:12] of the doorbell word
  function automatic logic [3:0] mbx_cmd_id(input logic [31:0] w);
    return w[15:12];
  endfunction

  function automatic logic mbx_cmd_ioc(input logic [31:0] w);
    return w[MBX_IOC_BIT];
  endfunction

  // status: [0] busy [1] error [2] overrun [7:4] id [15:8] initiator [23:16] code
  function automatic logic [31:0] mbx_status(input logic busy, input logic err,
                                             input logic ovr, input logic [3:0] id,
                                             input logic [7:0] init,
                                             input logic [7:0] code);
    return {8'h00, code, init, id, 1'b0, ovr, err, busy};
  endfunction

  function automatic logic mbx_in_win(input logic [7:0] a, input logic [7:0] base,
                                      input int len);
    return (int'(a) >= int'(base)) && (int'(a) < int'(base) + len);
  endfunction

  // byte lane extraction, little-endian
  function automatic logic [31:0] mbx_lane(input logic [31:0] w, input logic [1:0] lane);
    return {24'h0, w[{lane, 3'b000} +: 8]};
  endfunction
endpackage

// File: rtl/mbx_byte_buf.sv
module mbx_byte_buf #(
  parameter int WORDS = 4,
  localparam int SEL_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [SEL_W-1:0]      wsel,
  input  logic [3:0]            be,
  input  logic [31:0]           wdata,
  output logic [WORDS*32-1:0]   flat
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar b = 0; b < 4; b++) begin : g_lane
      logic [7:0] byte_q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          byte_q <= 8'h00;
        else if (we && be[b] && (int'(wsel) == w))
          byte_q <= wdata[b*8 +: 8];
      end
      assign flat[w*32 + b*8 +: 8] = byte_q;
    end
  end

  // R7 / R8: contents move only on a write strobe
  p_hold_without_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(flat));
endmodule

// File: rtl/mbx_cmd_ctrl.sv
module mbx_cmd_ctrl
  import mbx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  input  logic        sp_done,
  input  logic        sp_err,
  input  logic [7:0]  sp_code,
  input  logic [7:0]  sp_init,
  output logic [31:0] cmd_word,
  output logic [31:0] status_word,
  output logic        sp_irq,
  output logic        host_irq
);
  logic        busy_q, err_q, ovr_q, sp_irq_q, host_irq_q;
  logic [7:0]  code_q, init_q;
  logic [31:0] cmd_q;

  // named events for the assertions
  logic cmd_accept, cmd_drop, done_take;
  assign cmd_accept = cmd_wr && !busy_q;
  assign cmd_drop   = cmd_wr && busy_q;
  assign done_take  = sp_done && busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      err_q      <= 1'b0;
      ovr_q      <= 1'b0;
      code_q     <= 8'h00;
      init_q     <= 8'h00;
      cmd_q      <= 32'h0;
      sp_irq_q   <= 1'b0;
      host_irq_q <= 1'b0;
    end else begin
      sp_irq_q   <= cmd_accept;
      host_irq_q <= done_take && mbx_cmd_ioc(cmd_q);
      if (cmd_accept) begin
        cmd_q  <= cmd_wdata;
        busy_q <= 1'b1;
        err_q  <= 1'b0;
        code_q <= 8'h00;
        init_q <= 8'h00;
        ovr_q  <= 1'b0;
      end else if (done_take) begin
        busy_q <= 1'b0;
        err_q  <= sp_err;
        code_q <= sp_code;
        init_q <= sp_init;
      end
      if (cmd_drop)
        ovr_q <= 1'b1;
    end
  end

  assign cmd_word    = cmd_q;
  assign sp_irq      = sp_irq_q;
  assign host_irq    = host_irq_q;
  assign status_word = mbx_status(busy_q, err_q, ovr_q, mbx_cmd_id(cmd_q), init_q, code_q);

  p_accept_sets_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> (busy_q && sp_irq && cmd_word == $past(cmd_wdata)));
  p_drop_keeps_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_drop |=> ($stable(cmd_q) && ovr_q && !sp_irq));
  p_done_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_take |=> (!busy_q && err_q == $past(sp_err) && code_q == $past(sp_code)));
  p_idle_done_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_done && !busy_q && !cmd_wr) |=> ($stable(status_word) && !host_irq));
  p_host_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> ($past(done_take) && mbx_cmd_ioc(cmd_q)));
  p_host_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |=> !host_irq);
endmodule

// File: rtl/mbx_ipc_mailbox.sv
module mbx_ipc_mailbox
  import mbx_pkg::*;
#(
  parameter int BUF_BYTES = 16,
  localparam int WORDS = BUF_BYTES / 4,
  localparam int SEL_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_wr_en,
  input  logic              h_rd_en,
  input  logic              h_rd_byte,
  input  logic [7:0]        h_addr,
  input  logic [31:0]       h_wdata,
  input  logic [3:0]        h_be,
  output logic [31:0]       h_rdata,
  output logic              h_done_irq,
  output logic              sp_cmd_irq,
  output logic [31:0]       sp_cmd_word,
  input  logic [SEL_W-1:0]  sp_wbuf_sel,
  output logic [31:0]       sp_wbuf_word,
  input  logic              sp_rbuf_we,
  input  logic [SEL_W-1:0]  sp_rbuf_sel,
  input  logic [3:0]        sp_rbuf_be,
  input  logic [31:0]       sp_rbuf_wdata,
  input  logic              sp_done,
  input  logic              sp_done_err,
  input  logic [7:0]        sp_done_code,
  input  logic [7:0]        sp_done_init
);
  // address decode
  logic cmd_hit, stat_hit, wbuf_hit, rbuf_hit, rd_unmapped;
  assign cmd_hit     = (h_addr == MBX_CMD_OFS);
  assign stat_hit    = (h_addr == MBX_STAT_OFS);
  assign wbuf_hit    = mbx_in_win(h_addr, MBX_WBUF_OFS, BUF_BYTES);
  assign rbuf_hit    = mbx_in_win(h_addr, MBX_RBUF_OFS, BUF_BYTES);
  assign rd_unmapped = !(stat_hit || rbuf_hit);

  logic [SEL_W-1:0] h_wsel, h_rsel;
  assign h_wsel = SEL_W'((h_addr - MBX_WBUF_OFS) >> 2);
  assign h_rsel = SEL_W'((h_addr - MBX_RBUF_OFS) >> 2);

  logic [31:0] cmd_word, status_word;
  logic        sp_irq, host_irq;

  mbx_cmd_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (h_wr_en && cmd_hit),
    .cmd_wdata  (h_wdata),
    .sp_done    (sp_done),
    .sp_err     (sp_done_err),
    .sp_code    (sp_done_code),
    .sp_init    (sp_done_init),
    .cmd_word   (cmd_word),
    .status_word(status_word),
    .sp_irq     (sp_irq),
    .host_irq   (host_irq)
  );

  logic [WORDS*32-1:0] wbuf_flat, rbuf_flat;

  mbx_byte_buf #(.WORDS(WORDS)) u_wbuf (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (h_wr_en && wbuf_hit),
    .wsel (h_wsel),
    .be   (h_be),
    .wdata(h_wdata),
    .flat (wbuf_flat)
  );

  mbx_byte_buf #(.WORDS(WORDS)) u_rbuf (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (sp_rbuf_we),
    .wsel (sp_rbuf_sel),
    .be   (sp_rbuf_be),
    .wdata(sp_rbuf_wdata),
    .flat (rbuf_flat)
  );

  assign sp_wbuf_word = wbuf_flat[sp_wbuf_sel*32 +: 32];
  assign sp_cmd_word  = cmd_word;
  assign sp_cmd_irq   = sp_irq;
  assign h_done_irq   = host_irq;

  // host read path
  logic [31:0] rbuf_word, rd_next, rdata_q;
  assign rbuf_word = rbuf_flat[h_rsel*32 +: 32];

  always_comb begin
    rd_next = 32'h0;
    if (stat_hit)
      rd_next = status_word;
    else if (rbuf_hit)
      rd_next = h_rd_byte ? mbx_lane(rbuf_word, h_addr[1:0]) : rbuf_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rdata_q <= 32'h0;
    else if (h_rd_en)
      rdata_q <= rd_next;
  end
  assign h_rdata = rdata_q;

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd_en && rd_unmapped) |=> (h_rdata == 32'h0));
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !h_rd_en |=> $stable(h_rdata));
  p_byte_read_narrow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd_en && h_rd_byte && rbuf_hit) |=> (h_rdata[31:8] == 24'h0));
endmodule

// File: tb/tb_mbx_ipc_mailbox.sv
module tb_mbx_ipc_mailbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_wr_en = 0, h_rd_en = 0, h_rd_byte = 0;
  logic [7:0]  h_addr = 0;
  logic [31:0] h_wdata = 0;
  logic [3:0]  h_be = 0;
  logic [31:0] h_rdata;
  logic        h_done_irq, sp_cmd_irq;
  logic [31:0] sp_cmd_word, sp_wbuf_word;
  logic [1:0]  sp_wbuf_sel = 0, sp_rbuf_sel = 0;
  logic        sp_rbuf_we = 0;
  logic [3:0]  sp_rbuf_be = 0;
  logic [31:0] sp_rbuf_wdata = 0;
  logic        sp_done = 0, sp_done_err = 0;
  logic [7:0]  sp_done_code = 0, sp_done_init = 0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mbx_ipc_mailbox dut (.*);

  typedef struct { logic [31:0] exp; string tag; } rd_item_t;
  rd_item_t exp_q[$];
  logic rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= h_rd_en;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: data is valid at the falling edge after the capture edge
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 unexpected read data actual=%h expected=none", h_rdata);
      end else begin
        rd_item_t it;
        it = exp_q.pop_front();
        chk(h_rdata, it.exp, it.tag);
      end
    end
  end

  function automatic logic [31:0] exp_status(int busy, int err, int ovr, int id, int init, int code);
    return 32'((code << 16) + (init << 8) + (id << 4) + (ovr * 4) + (err * 2) + busy);
  endfunction

  task automatic host_read(input logic [7:0] a, input bit bytewise,
                           input logic [31:0] exp, input string tag);
    rd_item_t it;
    @(negedge clk);
    h_addr = a; h_rd_byte = bytewise; h_rd_en = 1;
    it.exp = exp; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    h_rd_en = 0; h_rd_byte = 0;
  endtask

  task automatic host_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    h_addr = a; h_wdata = d; h_be = be; h_wr_en = 1;
    @(negedge clk);
    h_wr_en = 0;
  endtask

  task automatic sp_write(input logic [1:0] sel, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    sp_rbuf_sel = sel; sp_rbuf_be = be; sp_rbuf_wdata = d; sp_rbuf_we = 1;
    @(negedge clk);
    sp_rbuf_we = 0;
  endtask

  task automatic sp_complete(input logic err, input logic [7:0] code, input logic [7:0] init);
    @(negedge clk);
    sp_done = 1; sp_done_err = err; sp_done_code = code; sp_done_init = init;
    @(negedge clk);
    sp_done = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk({31'h0, sp_cmd_irq}, 0, "R1 sp_cmd_irq");
    chk({31'h0, h_done_irq}, 0, "R1 h_done_irq");
    chk(sp_cmd_word, 0, "R1 cmd word");
    chk(sp_wbuf_word, 0, "R1 outbound word");
    host_read(8'h04, 0, 0, "R1 status");
    host_read(8'h90, 0, 0, "R1 inbound word");

    // R7 outbound area with byte enables
    host_write(8'h80, 32'h11223344, 4'hF);
    host_write(8'h84, 32'hAABBCCDD, 4'b0011);
    sp_wbuf_sel = 0; #1;
    chk(sp_wbuf_word, 32'h11223344, "R7 outbound word0");
    sp_wbuf_sel = 1; #1;
    chk(sp_wbuf_word, 32'h0000CCDD, "R7 outbound word1 partial");
    host_read(8'h80, 0, 0, "R7 outbound not host readable");

    // R2 accepted doorbell: size 3, id 5, ioc 1, command FF
    host_write(8'h00, 32'h000351FF, 4'hF);
    chk({31'h0, sp_cmd_irq}, 1, "R2 doorbell pulse");
    chk(sp_cmd_word, 32'h000351FF, "R2 latched command");
    @(negedge clk);
    chk({31'h0, sp_cmd_irq}, 0, "R2 pulse one cycle");
    host_read(8'h04, 0, exp_status(1, 0, 0, 5, 0, 0), "R2 busy status");
    host_read(8'h00, 0, 0, "R7 command offset reads zero");

    // R3 doorbell while busy dropped
    host_write(8'h00, 32'h00002011, 4'hF);
    chk({31'h0, sp_cmd_irq}, 0, "R3 no pulse when busy");
    chk(sp_cmd_word, 32'h000351FF, "R3 command kept");
    host_read(8'h04, 0, exp_status(1, 0, 1, 5, 0, 0), "R3 overrun set");

    // R8 inbound area
    sp_write(2'd0, 4'hF, 32'h04030201);
    sp_write(2'd1, 4'b0100, 32'h55770099);
    host_read(8'h90, 0, 32'h04030201, "R8 word read");
    host_read(8'h92, 1, 32'h00000003, "R8 byte read lane2");
    host_read(8'h90, 1, 32'h00000001, "R8 byte read lane0");
    host_read(8'h96, 1, 32'h00000077, "R8 byte read word1");
    host_read(8'h94, 0, 32'h00770000, "R8 partial enables");

    // R4 / R6 completion with ioc set
    sp_complete(1'b1, 8'h5A, 8'h3C);
    chk({31'h0, h_done_irq}, 1, "R6 host pulse with ioc");
    @(negedge clk);
    chk({31'h0, h_done_irq}, 0, "R6 host pulse one cycle");
    host_read(8'h04, 0, exp_status(0, 1, 1, 5, 8'h3C, 8'h5A), "R4 completion status");

    // R5 completion while idle
    sp_complete(1'b0, 8'h11, 8'h22);
    chk({31'h0, h_done_irq}, 0, "R5 no host pulse when idle");
    host_read(8'h04, 0, exp_status(0, 1, 1, 5, 8'h3C, 8'h5A), "R5 status unchanged");

    // R9 host writes to status and inbound area ignored
    host_write(8'h04, 32'hFFFFFFFF, 4'hF);
    host_write(8'h90, 32'hDEADBEEF, 4'hF);
    host_read(8'h04, 0, exp_status(0, 1, 1, 5, 8'h3C, 8'h5A), "R9 status write ignored");
    host_read(8'h90, 0, 32'h04030201, "R9 inbound write ignored");

    // R4 / R6 new command without ioc clears error and overrun
    host_write(8'h00, 32'h0000A012, 4'hF);
    host_read(8'h04, 0, exp_status(1, 0, 0, 10, 0, 0), "R4 accept clears error");
    sp_complete(1'b0, 8'h00, 8'h07);
    chk({31'h0, h_done_irq}, 0, "R6 no host pulse without ioc");
    host_read(8'h04, 0, exp_status(0, 0, 0, 10, 8'h07, 0), "R4 second completion");

    // R10 unmapped offset and hold
    host_read(8'h40, 0, 0, "R10 unmapped reads zero");
    repeat (2) @(negedge clk);
    chk(h_rdata, 0, "R10 read data held");

    // R1 reset again clears buffers
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    sp_wbuf_sel = 0; #1;
    chk(sp_wbuf_word, 0, "R1 outbound cleared");
    host_read(8'h90, 0, 0, "R1 inbound cleared");
    host_read(8'h04, 0, 0, "R1 status cleared");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R10 pending reads actual=%0d expected=0", exp_q.size());
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule